// File: doc/BRIEF.md
# Latched Status Interrupt Controller

This block watches a vector of per-channel condition inputs and turns them into two software views. The live view mirrors the conditions as they are right now. The sticky view records every condition that has been seen until software clears it. Software clears sticky bits by writing ones to them. Per-bit enables combine the sticky bits into one interrupt request.

A single mode bit selects edge or level behaviour for the whole register. In edge mode, a cleared bit is set again only by a fresh 0-to-1 transition of its condition. In level mode, a cleared bit is set again at once if its condition is still present, so a persistent condition keeps requesting service. After a request fires, the block stays silent until software clears sticky bits. A programmable vector value sits beside the request, and a steering bit sends the request to either the host-side output or the local-processor output.

The register port is synchronous. Writes take effect at the clock edge. Read data is registered and is valid in the cycle after the address is presented.

Top module: `stat_irq_ctrl`

## Requirements
- R1: Register address 0 (read-only) returns the current condition vector. A bit reads 0 again as soon as its condition drops. Writes to address 0 have no effect.
- R2: A sticky bit (address 1) becomes 1 in the cycle after its set condition is seen. It stays 1 after the condition ends, until it is cleared.
- R3: Writing address 1 clears each sticky bit whose written data bit is 1. Bits written with 0 are left unchanged.
- R4: In edge mode (address 3 bit 0 = 0), a bit sets only on a 0-to-1 transition of its condition. A cleared bit stays 0 while its condition is held, and sets again on the next transition.
- R5: In level mode (address 3 bit 0 = 1), a bit sets in every cycle its condition is 1. For example, with conditions at 0xC, writing 0xE to address 1 leaves 0xC.
- R6: If a clearing write and a set event hit the same bit in the same cycle, the bit ends up 1.
- R7: With no clearing, the sticky value is the OR of all conditions seen. For example, the sequence 0x1, 0x0, 0x2, 0xC gives 0xF.
- R8: Enable bits (address 2) map one-to-one onto sticky bits. When the block is armed and (sticky AND enable) is nonzero, a one-cycle request pulse is produced. A sticky bit that is not enabled produces no request.
- R9: After a request fires, no further request is produced until a write to address 1 with a nonzero value. In level mode, a held condition fires again after each such clear. In edge mode, it does not.
- R10: Steering (address 5 bit 0) sends the request pulse to the host output when 0 and to the local output when 1. The other output stays low. The vector output always shows the vector register (address 4).
- R11: After reset, every register reads 0, both request outputs are low, and the block is armed.
- R12: The enable, mode, vector and steering registers read back what was written. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | NCH | Condition inputs, synchronous to clk |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data for the previous cycle's address |
| irq_host_o | output | 1 | One-cycle request pulse, host-side destination |
| irq_local_o | output | 1 | One-cycle request pulse, local-processor destination |
| irq_vec_o | output | VEC_W | Vector value reported with the request |

## Verification
The condition vector is driven through several patterns:
- A single pulse that drops again, which separates the live view from the sticky view.
- A walking sequence with no clearing, which shows OR accumulation.
- A condition held across a clear, run once in each mode. This pattern is where edge and level behaviour differ.
- A rising edge placed in the same cycle as a clearing write, which checks that set takes priority.

The request outputs are then counted under three cases:
- A bit that is set but not enabled.
- A held condition in edge mode.
- A held condition in level mode with repeated clears.

These counts show whether the block blocks after firing, re-arms on a clear, and steers to the right output.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        SEL_LIVE   = 3'd0,
        SEL_STICKY = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_VECTOR = 3'd4,
        SEL_STEER  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/stat_latch.sv
module stat_latch #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cond_i,
    input  logic           level_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] sticky_o
);
    typedef struct packed {
        logic [NCH-1:0] sticky;
        logic [NCH-1:0] prev;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [NCH-1:0] set_v;

    always_comb begin
        set_v        = level_i ? cond_i : (cond_i & ~st_q.prev);
        st_d.prev    = cond_i;
        st_d.sticky  = (st_q.sticky & ~clr_i) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_o = st_q.sticky;

    // R2: a set bit survives unless a clear hits it
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sticky & $past(st_q.sticky & ~clr_i)) == $past(st_q.sticky & ~clr_i)));
    // R3: a cleared bit with no set event reads 0 next cycle
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_v)) |=> ((st_q.sticky & $past(clr_i & ~set_v)) == '0));
    // R6: set has priority over a same-cycle clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & set_v)) |=> ((st_q.sticky & $past(clr_i & set_v)) == $past(clr_i & set_v)));
endmodule

// File: rtl/stat_regs.sv
module stat_regs
    import stat_irq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int VEC_W = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NCH-1:0]    cond_i,
    input  logic [NCH-1:0]    sticky_i,
    output logic [NCH-1:0]    enable_o,
    output logic              level_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              steer_o,
    output logic [NCH-1:0]    clr_o,
    output logic              clr_any_o,
    output logic [DW-1:0]     rdata_o
);
    typedef struct packed {
        logic [NCH-1:0]   enable;
        logic             level;
        logic [VEC_W-1:0] vec;
        logic             steer;
        logic [DW-1:0]    rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel   = reg_sel_e'(addr_i);
        st_d  = st_q;
        clr_o = '0;
        if (we_i) begin
            case (sel)
                SEL_STICKY: clr_o        = wdata_i[NCH-1:0];
                SEL_ENABLE: st_d.enable  = wdata_i[NCH-1:0];
                SEL_MODE:   st_d.level   = wdata_i[0];
                SEL_VECTOR: st_d.vec     = wdata_i[VEC_W-1:0];
                SEL_STEER:  st_d.steer   = wdata_i[0];
                default:    ;
            endcase
        end
        case (sel)
            SEL_LIVE:   st_d.rdata = DW'(cond_i);
            SEL_STICKY: st_d.rdata = DW'(sticky_i);
            SEL_ENABLE: st_d.rdata = DW'(st_q.enable);
            SEL_MODE:   st_d.rdata = DW'(st_q.level);
            SEL_VECTOR: st_d.rdata = DW'(st_q.vec);
            SEL_STEER:  st_d.rdata = DW'(st_q.steer);
            default:    st_d.rdata = '0;
        endcase
        clr_any_o = |clr_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;
    assign level_o  = st_q.level;
    assign vec_o    = st_q.vec;
    assign steer_o  = st_q.steer;
    assign rdata_o  = st_q.rdata;

    // R12: configuration changes only through a write
    a_r12_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(st_q.enable) && $stable(st_q.vec) && $stable(st_q.level) && $stable(st_q.steer)));
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sticky_i,
    input  logic [NCH-1:0] enable_i,
    input  logic           clr_any_i,
    input  logic           steer_i,
    output logic           host_o,
    output logic           local_o
);
    typedef struct packed {
        logic armed;
        logic host;
        logic loc;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic fire;

    always_comb begin
        fire       = st_q.armed && (|(sticky_i & enable_i));
        st_d.host  = fire && !steer_i;
        st_d.loc   = fire && steer_i;
        if (clr_any_i)  st_d.armed = 1'b1;
        else if (fire)  st_d.armed = 1'b0;
        else            st_d.armed = st_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1, host: 1'b0, loc: 1'b0};
        else        st_q <= st_d;
    end

    assign host_o  = st_q.host;
    assign local_o = st_q.loc;

    // R9: a disarmed block with no clearing write stays silent
    a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !clr_any_i) |=> !(host_o || local_o));
    // R10: at most one destination per pulse
    a_r10_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_o, local_o}));
    // R8: a pulse needs an enabled sticky bit one cycle earlier
    a_r8_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_i & enable_i) == '0) |=> !(host_o || local_o));
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
    import stat_irq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int VEC_W = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cond_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              irq_host_o,
    output logic              irq_local_o,
    output logic [VEC_W-1:0]  irq_vec_o
);
    logic [NCH-1:0] sticky, enable, clr;
    logic           level, steer, clr_any;
    wire            unused_wdata_hi = ^reg_wdata_i;

    initial begin
        assert (NCH >= 1 && NCH <= 32 && NCH <= DW && VEC_W <= DW)
            else $error("stat_irq_ctrl: bad parameter set");
    end

    stat_regs #(.NCH(NCH), .VEC_W(VEC_W), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .cond_i    (cond_i),
        .sticky_i  (sticky),
        .enable_o  (enable),
        .level_o   (level),
        .vec_o     (irq_vec_o),
        .steer_o   (steer),
        .clr_o     (clr),
        .clr_any_o (clr_any),
        .rdata_o   (reg_rdata_o)
    );

    stat_latch #(.NCH(NCH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_i),
        .level_i  (level),
        .clr_i    (clr),
        .sticky_o (sticky)
    );

    irq_gen #(.NCH(NCH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sticky_i  (sticky),
        .enable_i  (enable),
        .clr_any_i (clr_any),
        .steer_i   (steer),
        .host_o    (irq_host_o),
        .local_o   (irq_local_o)
    );
endmodule

// File: tb/stat_irq_ctrl_bench.sv
module stat_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int VW  = 8;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] cond = '0;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ih, il;
    logic [VW-1:0] vec;

    stat_irq_ctrl #(.NCH(NCH), .VEC_W(VW), .DW(DW)) u_stat_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_host_o(ih), .irq_local_o(il), .irq_vec_o(vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t  sb[$];
    int cyc = 0, nchk = 0, nfail = 0, hcnt = 0, lcnt = 0;
    bit finished = 0;

    always @(posedge clk) begin
        cyc++;
        #2;
        if (ih) hcnt++;
        if (il) lcnt++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read results when they are due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_item_t it;
            it = sb.pop_front();
            chk(it.tag, rdata, it.exp);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        exp_item_t it;
        @(negedge clk);
        we = 1'b0; addr = a;
        it.due = cyc + 1; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic setc(logic [NCH-1:0] v);
        @(negedge clk);
        cond = v;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int h0, l0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R11 reset register");
        chk("R11 irq outputs low", {30'h0, ih, il}, 32'h0);
        chk("R11 no pulses", hcnt + lcnt, 0);

        // R1 live view, R2 sticky
        setc(8'h01); idle(1);
        rd(3'd0, 32'h01, "R1 live follows condition");
        setc(8'h00); idle(1);
        rd(3'd0, 32'h00, "R1 live drops");
        rd(3'd1, 32'h01, "R2 sticky holds after condition ends");
        wr(3'd0, 32'hFF);
        rd(3'd0, 32'h00, "R1 write to live ignored");

        // R7 accumulation
        setc(8'h02); setc(8'h0C); idle(1);
        rd(3'd1, 32'h0F, "R7 OR accumulation 0xF");
        setc(8'h00);

        // R3 write-1-to-clear
        wr(3'd1, 32'h05);
        rd(3'd1, 32'h0A, "R3 clear only ones");
        wr(3'd1, 32'h00);
        rd(3'd1, 32'h0A, "R3 zero write leaves bits");
        wr(3'd1, 32'hFF);
        rd(3'd1, 32'h00, "R3 clear all");

        // R4 edge mode with held condition
        setc(8'h02); idle(2);
        rd(3'd1, 32'h02, "R4 edge sets on rise");
        wr(3'd1, 32'h02); idle(3);
        rd(3'd1, 32'h00, "R4 held condition stays cleared");
        setc(8'h00); idle(1); setc(8'h02); idle(1);
        rd(3'd1, 32'h02, "R4 new rise sets again");
        setc(8'h00); wr(3'd1, 32'h02);

        // R5 level mode
        wr(3'd3, 32'h1);
        setc(8'h0C); idle(2);
        wr(3'd1, 32'h0E);
        rd(3'd1, 32'h0C, "R5 level re-sets held bits");
        setc(8'h00); wr(3'd1, 32'h0C);
        rd(3'd1, 32'h00, "R5 level clears when condition gone");

        // R6 set beats clear (edge mode)
        wr(3'd3, 32'h0);
        @(negedge clk);
        cond = 8'h01; we = 1'b1; addr = 3'd1; wdata = 32'h01;
        @(negedge clk);
        we = 1'b0;
        rd(3'd1, 32'h01, "R6 set wins over clear");
        wr(3'd1, 32'h01);
        rd(3'd1, 32'h00, "R4 clear after edge with held condition");
        setc(8'h00);

        // R12 readback
        wr(3'd2, 32'hA5);   rd(3'd2, 32'hA5, "R12 enable readback");
        wr(3'd4, 32'h3C);   rd(3'd4, 32'h3C, "R12 vector readback");
        wr(3'd5, 32'h1);    rd(3'd5, 32'h1,  "R12 steer readback");
        wr(3'd3, 32'h1);    rd(3'd3, 32'h1,  "R12 mode readback");
        wr(3'd3, 32'h0);
        wr(3'd5, 32'h0);
        wr(3'd2, 32'h00);
        wr(3'd4, 32'h5A);
        chk("R10 vector output", vec, 32'h5A);

        // R8 enable gating, R9 blocking, R10 host steering (edge mode)
        wr(3'd2, 32'h01);
        h0 = hcnt; l0 = lcnt;
        setc(8'h02); idle(4);
        chk("R8 disabled bit no request", hcnt - h0, 0);
        setc(8'h01); idle(4);
        chk("R8 enabled bit fires once", hcnt - h0, 1);
        chk("R10 local stays low when steered host", lcnt - l0, 0);
        idle(6);
        chk("R9 blocked after firing", hcnt - h0, 1);
        wr(3'd1, 32'h03); idle(5);
        chk("R9 edge no refire on held condition", hcnt - h0, 1);
        setc(8'h00);

        // R9 level refire, R10 local steering
        wr(3'd3, 32'h1);
        wr(3'd5, 32'h1);
        h0 = hcnt; l0 = lcnt;
        setc(8'h01); idle(4);
        chk("R10 local pulse", lcnt - l0, 1);
        idle(5);
        chk("R9 level blocked until clear", lcnt - l0, 1);
        wr(3'd1, 32'h01); idle(4);
        chk("R9 level refire after clear", lcnt - l0, 2);
        wr(3'd1, 32'h01); idle(4);
        chk("R9 level refire again", lcnt - l0, 3);
        chk("R10 host stays low when steered local", hcnt - h0, 0);
        setc(8'h00); wr(3'd1, 32'h01); idle(5);
        chk("R9 no refire once condition gone", lcnt - l0, 3);
        rd(3'd1, 32'h00, "R5 sticky empty after final clear");

        idle(3);
        finish_run();
    end
endmodule